// File: doc/BRIEF.md
# Station Address Table Loader and Receive Filter

This block keeps a table of 16 station addresses, 48 bits each, and uses it to decide whether an incoming frame is meant for this node. Software fills the table by placing a list of address descriptors in system memory and setting a load command. A load engine then walks that list through a read-only memory master port and writes one table entry per descriptor. After the last entry it reads one more word, which becomes the 16-bit mask that says which entries take part in matching.

The receive side takes a frame's destination address with a one-cycle strobe. In the next cycle it gives exactly one verdict, accept or reject, together with a code that names the rule that accepted the frame. The rules are promiscuous unicast, all-multicast, broadcast, and an exact match against an enabled table entry. While the device is held in its reset mode, software can read back any entry as three 16-bit byte pairs.

Top module: `addr_cam_filter`

## Requirements
- R1: A load starts on `load_start` while idle. It fills as many entries as the low 5 bits of `desc_count` give, starting at entry 0, and bits 15..5 of the count are ignored. A count of zero performs only the mask fetch. `load_start` while a load is running is ignored.
- R2: Slot size S is 2 bytes when `wide_bus`=0 and 4 bytes when `wide_bus`=1. A descriptor occupies four slots. Word k of descriptor j is read at `desc_ptr + (4*j + k)*S` for k = 1, 2, 3 in that order. The mask word is read at `desc_ptr + 4*n*S`, where n is the entry count.
- R3: For each entry, words 1, 2 and 3 supply address bytes 0/1, 2/3 and 4/5. The low byte of each word goes to the lower-numbered byte. Only bits 15..0 of a response are used, and bits 31..16 are ignored.
- R4: The 16-bit entry-enable mask takes the value of bits 15..0 of the final response of a load. Bit i enables entry i.
- R5: `load_busy` is high from the cycle after an accepted start until the final response is taken. `load_done_irq` is a single-cycle pulse in the cycle `load_busy` falls.
- R6: The engine keeps at most one read outstanding. It holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready`, and it issues no new request until `mem_rsp_valid` has returned the data for the previous one.
- R7: With `promisc_en` set, a destination whose byte 0 (bits 7..0 of `frame_dst`) has bit 0 clear is accepted with kind 1. A destination with bit 0 set is not accepted by this rule.
- R8: With `all_mcast_en` set, a destination whose byte 0 has bit 0 set is accepted with kind 2. The all-ones broadcast address is included.
- R9: With `bcast_en` set, the all-ones destination is accepted with kind 3, unless the R8 rule already accepts it.
- R10: Otherwise a frame is accepted with kind 0 only if it equals an entry whose enable bit is set. A frame that meets no rule is rejected.
- R11: Each `frame_valid` cycle gives, in the following cycle, exactly one single-cycle pulse on either `frame_accept` or `frame_reject`. Neither output pulses in any other cycle.
- R12: With `reset_mode` high, `rb_word_lo`, `rb_word_mid` and `rb_word_hi` return bytes 1:0, 3:2 and 5:4 of the entry selected by `rb_ptr`, with the higher-numbered byte in bits 15..8. With `reset_mode` low all three read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_start | input | 1 | Load command strobe |
| wide_bus | input | 1 | 1: 32-bit memory slots, 0: 16-bit slots |
| desc_ptr | input | 32 | Byte address of the first descriptor |
| desc_count | input | 16 | Descriptor count, low 5 bits used |
| load_busy | output | 1 | Load in progress |
| load_done_irq | output | 1 | Load finished, one-cycle pulse |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data, bits 15..0 used |
| frame_valid | input | 1 | Destination address strobe |
| frame_dst | input | 48 | Destination, byte 0 in bits 7..0 |
| promisc_en | input | 1 | Accept all unicast |
| all_mcast_en | input | 1 | Accept all multicast |
| bcast_en | input | 1 | Accept broadcast |
| frame_accept | output | 1 | Frame accepted, one cycle |
| frame_reject | output | 1 | Frame rejected, one cycle |
| accept_kind | output | 2 | 0 table, 1 promiscuous, 2 multicast, 3 broadcast |
| reset_mode | input | 1 | Device reset mode, enables readback |
| rb_ptr | input | 4 | Readback entry select |
| rb_word_hi | output | 16 | Bytes 5/4 of the selected entry |
| rb_word_mid | output | 16 | Bytes 3/2 of the selected entry |
| rb_word_lo | output | 16 | Bytes 1/0 of the selected entry |

## Verification
The filter verdict is registered once, so a frame strobed before one edge is judged on the outputs sampled at the falling edge after it. The scoreboard pops one expected verdict for every pulse seen there and reports any pulse that arrives with nothing queued. Each memory request is compared against the next expected address when the handshake is decided, and its response returns two cycles after that edge. The done pulse and the busy drop are therefore checked only after the last response has been taken. Readback is combinational from the table, so it is sampled one time step after `reset_mode` and `rb_ptr` change.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int MAC_W  = 48;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    KIND_TABLE   = 2'd0,
    KIND_PROMISC = 2'd1,
    KIND_MCAST   = 2'd2,
    KIND_BCAST   = 2'd3
  } match_kind_e;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_REQ  = 2'd1,
    LD_WAIT = 2'd2
  } ld_state_e;
endpackage

// File: rtl/cam_load_engine.sv
module cam_load_engine
  import cam_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       wide,
  input  logic [ADDR_W-1:0]          ptr,
  input  logic [15:0]                count,
  output logic                       busy,
  output logic                       done_pulse,
  output logic                       req_valid,
  input  logic                       req_ready,
  output logic [ADDR_W-1:0]          req_addr,
  input  logic                       rsp_valid,
  input  logic [DATA_W-1:0]          rsp_data,
  output logic                       wr_en,
  output logic [$clog2(ENTRIES)-1:0] wr_idx,
  output logic [MAC_W-1:0]           wr_data,
  output logic                       mask_wr_en,
  output logic [ENTRIES-1:0]         mask_data
);
  localparam int IDX_W = $clog2(ENTRIES);

  ld_state_e             state_q, state_d;
  logic [ADDR_W-1:0]     base_q, base_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [1:0]            word_q, word_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [WORD_W-1:0]     w1_q, w1_d, w2_q, w2_d;
  logic                  wide_q, wide_d;
  logic                  mphase_q, mphase_d;
  logic                  done_q, done_d;
  logic [ADDR_W-1:0]     slot_off, desc_size;
  logic                  unused_bits;

  assign unused_bits = ^{rsp_data[DATA_W-1:WORD_W], count[15:CNT_W]};

  assign slot_off  = ADDR_W'(word_q) << (wide_q ? 2 : 1);
  assign desc_size = wide_q ? ADDR_W'(16) : ADDR_W'(8);

  assign busy       = (state_q != LD_IDLE);
  assign done_pulse = done_q;
  assign req_valid  = (state_q == LD_REQ);
  assign req_addr   = base_q + slot_off;
  assign wr_idx     = idx_q;
  assign wr_data    = {rsp_data[WORD_W-1:0], w2_q, w1_q};
  assign mask_data  = rsp_data[ENTRIES-1:0];

  always_comb begin
    state_d    = state_q;
    base_d     = base_q;
    cnt_d      = cnt_q;
    word_d     = word_q;
    idx_d      = idx_q;
    w1_d       = w1_q;
    w2_d       = w2_q;
    wide_d     = wide_q;
    mphase_d   = mphase_q;
    done_d     = 1'b0;
    wr_en      = 1'b0;
    mask_wr_en = 1'b0;
    case (state_q)
      LD_IDLE: begin
        if (start) begin
          base_d   = ptr;
          cnt_d    = count[CNT_W-1:0];
          wide_d   = wide;
          idx_d    = '0;
          mphase_d = (count[CNT_W-1:0] == '0);
          word_d   = (count[CNT_W-1:0] == '0) ? 2'd0 : 2'd1;
          state_d  = LD_REQ;
        end
      end
      LD_REQ: begin
        if (req_ready) state_d = LD_WAIT;
      end
      LD_WAIT: begin
        if (rsp_valid) begin
          if (mphase_q) begin
            mask_wr_en = 1'b1;
            done_d     = 1'b1;
            state_d    = LD_IDLE;
          end else begin
            state_d = LD_REQ;
            case (word_q)
              2'd1: begin
                w1_d   = rsp_data[WORD_W-1:0];
                word_d = 2'd2;
              end
              2'd2: begin
                w2_d   = rsp_data[WORD_W-1:0];
                word_d = 2'd3;
              end
              default: begin
                wr_en  = 1'b1;
                cnt_d  = cnt_q - CNT_W'(1);
                idx_d  = idx_q + IDX_W'(1);
                base_d = base_q + desc_size;
                if (cnt_q == CNT_W'(1)) begin
                  mphase_d = 1'b1;
                  word_d   = 2'd0;
                end else begin
                  word_d = 2'd1;
                end
              end
            endcase
          end
        end
      end
      default: state_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= LD_IDLE;
      base_q   <= '0;
      cnt_q    <= '0;
      word_q   <= '0;
      idx_q    <= '0;
      w1_q     <= '0;
      w2_q     <= '0;
      wide_q   <= 1'b0;
      mphase_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      base_q   <= base_d;
      cnt_q    <= cnt_d;
      word_q   <= word_d;
      idx_q    <= idx_d;
      w1_q     <= w1_d;
      w2_q     <= w2_d;
      wide_q   <= wide_d;
      mphase_q <= mphase_d;
      done_q   <= done_d;
    end
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));
  // R6
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);
  // R5
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_pulse);
  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
endmodule

// File: rtl/cam_table.sv
module cam_table
  import cam_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [MAC_W-1:0]           wr_data,
  input  logic                       mask_wr_en,
  input  logic [ENTRIES-1:0]         mask_data,
  output logic [ENTRIES*MAC_W-1:0]   entries_flat,
  output logic [ENTRIES-1:0]         enable_mask,
  input  logic                       rd_allow,
  input  logic [$clog2(ENTRIES)-1:0] rd_ptr,
  output logic [WORD_W-1:0]          rb_hi,
  output logic [WORD_W-1:0]          rb_mid,
  output logic [WORD_W-1:0]          rb_lo
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [MAC_W-1:0]   ent_q [ENTRIES];
  logic [ENTRIES-1:0] en_q;
  logic [MAC_W-1:0]   sel;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g))) ent_q[g] <= wr_data;
    end
    assign entries_flat[g*MAC_W +: MAC_W] = ent_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (mask_wr_en) en_q <= mask_data;
  end

  assign enable_mask = en_q;
  assign sel    = rd_allow ? ent_q[rd_ptr] : '0;
  assign rb_lo  = sel[15:0];
  assign rb_mid = sel[31:16];
  assign rb_hi  = sel[47:32];

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_en |=> enable_mask == $past(mask_data));
  // R12
  rb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_allow |-> (rb_lo == '0 && rb_mid == '0 && rb_hi == '0));
endmodule

// File: rtl/cam_filter.sv
module cam_filter
  import cam_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_valid,
  input  logic [MAC_W-1:0]         dst,
  input  logic                     promisc,
  input  logic                     all_mcast,
  input  logic                     bcast,
  input  logic [ENTRIES*MAC_W-1:0] entries_flat,
  input  logic [ENTRIES-1:0]       enable_mask,
  output logic                     accept,
  output logic                     reject,
  output match_kind_e              kind
);
  logic [ENTRIES-1:0] hit;
  logic               is_mc, is_bc;
  logic               acc_d;
  match_kind_e        kind_d;
  logic               acc_q, rej_q;
  match_kind_e        kind_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit[g] = enable_mask[g] && (entries_flat[g*MAC_W +: MAC_W] == dst);
  end

  assign is_mc = dst[0];
  assign is_bc = &dst;

  always_comb begin
    acc_d  = 1'b1;
    kind_d = KIND_TABLE;
    if (promisc && !is_mc)        kind_d = KIND_PROMISC;
    else if (all_mcast && is_mc)  kind_d = KIND_MCAST;
    else if (bcast && is_bc)      kind_d = KIND_BCAST;
    else if (|hit)                kind_d = KIND_TABLE;
    else                          acc_d  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      rej_q  <= 1'b0;
      kind_q <= KIND_TABLE;
    end else begin
      acc_q <= frame_valid && acc_d;
      rej_q <= frame_valid && !acc_d;
      if (frame_valid) kind_q <= kind_d;
    end
  end

  assign accept = acc_q;
  assign reject = rej_q;
  assign kind   = kind_q;

  // R11
  verdict_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> (accept != reject));
  // R11
  verdict_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> !accept && !reject);
  // R7
  promisc_uni_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && promisc && !dst[0] |=> accept && kind == KIND_PROMISC);
  // R8
  mcast_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && all_mcast && dst[0] |=> accept && kind == KIND_MCAST);
endmodule

// File: rtl/addr_cam_filter.sv
module addr_cam_filter
  import cam_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_start,
  input  logic                       wide_bus,
  input  logic [ADDR_W-1:0]          desc_ptr,
  input  logic [15:0]                desc_count,
  output logic                       load_busy,
  output logic                       load_done_irq,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic [ADDR_W-1:0]          mem_req_addr,
  input  logic                       mem_rsp_valid,
  input  logic [DATA_W-1:0]          mem_rsp_data,
  input  logic                       frame_valid,
  input  logic [47:0]                frame_dst,
  input  logic                       promisc_en,
  input  logic                       all_mcast_en,
  input  logic                       bcast_en,
  output logic                       frame_accept,
  output logic                       frame_reject,
  output logic [1:0]                 accept_kind,
  input  logic                       reset_mode,
  input  logic [$clog2(ENTRIES)-1:0] rb_ptr,
  output logic [15:0]                rb_word_hi,
  output logic [15:0]                rb_word_mid,
  output logic [15:0]                rb_word_lo
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic                     wr_en, mask_wr_en;
  logic [IDX_W-1:0]         wr_idx;
  logic [MAC_W-1:0]         wr_data;
  logic [ENTRIES-1:0]       mask_data, enable_mask;
  logic [ENTRIES*MAC_W-1:0] entries_flat;
  match_kind_e              kind;

  cam_load_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .start(load_start), .wide(wide_bus),
    .ptr(desc_ptr), .count(desc_count), .busy(load_busy),
    .done_pulse(load_done_irq), .req_valid(mem_req_valid),
    .req_ready(mem_req_ready), .req_addr(mem_req_addr),
    .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .mask_wr_en(mask_wr_en), .mask_data(mask_data)
  );

  cam_table #(.ENTRIES(ENTRIES)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .mask_wr_en(mask_wr_en), .mask_data(mask_data),
    .entries_flat(entries_flat), .enable_mask(enable_mask),
    .rd_allow(reset_mode), .rd_ptr(rb_ptr),
    .rb_hi(rb_word_hi), .rb_mid(rb_word_mid), .rb_lo(rb_word_lo)
  );

  cam_filter #(.ENTRIES(ENTRIES)) u_filter (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .dst(frame_dst),
    .promisc(promisc_en), .all_mcast(all_mcast_en), .bcast(bcast_en),
    .entries_flat(entries_flat), .enable_mask(enable_mask),
    .accept(frame_accept), .reject(frame_reject), .kind(kind)
  );

  assign accept_kind = kind;
endmodule

// File: tb/test_addr_cam_filter.sv
module test_addr_cam_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_start, wide_bus;
  logic [31:0] desc_ptr;
  logic [15:0] desc_count;
  logic        load_busy, load_done_irq;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_rsp_data;
  logic        frame_valid;
  logic [47:0] frame_dst;
  logic        promisc_en, all_mcast_en, bcast_en;
  logic        frame_accept, frame_reject;
  logic [1:0]  accept_kind;
  logic        reset_mode;
  logic [3:0]  rb_ptr;
  logic [15:0] rb_word_hi, rb_word_mid, rb_word_lo;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  bit finished = 0;

  logic [15:0] mem [0:1023];
  logic [31:0] exp_addr_q [$];
  logic [2:0]  exp_verdict_q [$];

  always #2 clk = ~clk;

  addr_cam_filter i_addr_cam_filter (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder and request address monitor (R2, R6)
  initial begin
    int tick = 0;
    int rsp_cnt = 0;
    logic [31:0] held;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    held = '0;
    forever begin
      @(negedge clk);
      tick++;
      mem_rsp_valid = 1'b0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = {16'hBEEF, mem[held[10:1]]};
        end
      end
      mem_req_ready = (tick % 3) != 1;
      if (mem_req_valid && mem_req_ready && rst_n) begin
        // R6: no request while a response is pending
        if (rsp_cnt != 0) check(0, "R6", 64'(rsp_cnt), 0);
        if (exp_addr_q.size() == 0) check(0, "R2", mem_req_addr, 0);
        else begin
          logic [31:0] e;
          e = exp_addr_q.pop_front();
          check(mem_req_addr == e, "R2", mem_req_addr, e);
        end
        held = mem_req_addr;
        rsp_cnt = 2;
      end
    end
  end

  // verdict monitor (R11) and irq counter
  initial begin
    forever begin
      @(negedge clk);
      if (load_done_irq) irq_cnt++;
      if (frame_accept || frame_reject) begin
        logic [2:0] act;
        act = {frame_accept, frame_accept ? accept_kind : 2'b00};
        if (frame_accept && frame_reject) check(0, "R11", 64'(3), 64'(1));
        else if (exp_verdict_q.size() == 0) check(0, "R11", act, 0);
        else begin
          logic [2:0] e;
          e = exp_verdict_q.pop_front();
          check(act == e, "R7-R10 verdict", act, e);
        end
      end
    end
  end

  task automatic put_entry(input int base, input int s, input int j, input logic [47:0] mac);
    mem[(base + (4*j+1)*s) >> 1] = mac[15:0];
    mem[(base + (4*j+2)*s) >> 1] = mac[31:16];
    mem[(base + (4*j+3)*s) >> 1] = mac[47:32];
  endtask

  task automatic put_mask(input int base, input int s, input int n, input logic [15:0] m);
    mem[(base + 4*n*s) >> 1] = m;
  endtask

  task automatic run_load(input int base, input bit wide, input logic [15:0] cnt,
                          input bit poke_again);
    int s = wide ? 4 : 2;
    int n = int'(cnt[4:0]);
    int irq0 = irq_cnt;
    for (int j = 0; j < n; j++)
      for (int k = 1; k <= 3; k++) exp_addr_q.push_back(32'(base + (4*j+k)*s));
    exp_addr_q.push_back(32'(base + 4*n*s));
    @(negedge clk);
    desc_ptr = 32'(base); wide_bus = wide; desc_count = cnt; load_start = 1'b1;
    @(negedge clk);
    load_start = 1'b0;
    // R5: busy rises the cycle after start
    check(load_busy == 1'b1, "R5 busy", load_busy, 1);
    if (poke_again) begin
      repeat (3) @(negedge clk);
      desc_ptr = 32'h3F0; load_start = 1'b1;  // R1: ignored while busy
      @(negedge clk);
      load_start = 1'b0;
    end
    for (int t = 0; t < 2000 && load_busy; t++) @(negedge clk);
    repeat (2) @(negedge clk);
    check(load_busy == 1'b0, "R5 busy end", load_busy, 0);
    check(irq_cnt - irq0 == 1, "R5 irq", 64'(irq_cnt - irq0), 1);
    check(exp_addr_q.size() == 0, "R1/R2 reads", 64'(exp_addr_q.size()), 0);
  endtask

  task automatic rb_check(input int idx, input logic [47:0] mac, input string req);
    @(negedge clk);
    reset_mode = 1'b1; rb_ptr = 4'(idx);
    #1;
    check({rb_word_hi, rb_word_mid, rb_word_lo} == mac, req,
          {rb_word_hi, rb_word_mid, rb_word_lo}, mac);
  endtask

  task automatic send(input logic [47:0] dst, input bit acc, input logic [1:0] kind);
    @(negedge clk);
    frame_valid = 1'b1; frame_dst = dst;
    exp_verdict_q.push_back({acc, acc ? kind : 2'b00});
    @(negedge clk);
    frame_valid = 1'b0;
  endtask

  localparam logic [47:0] A0 = 48'h6655_4433_2210;
  localparam logic [47:0] A1 = 48'h0B0A_0908_0706;
  localparam logic [47:0] A2 = 48'hC0FF_EE00_BA02;
  localparam logic [47:0] B0 = 48'h1111_2222_3344;
  localparam logic [47:0] B1 = 48'hAB12_CD34_EF56;
  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
    rst_n = 1'b0; load_start = 0; wide_bus = 0; desc_ptr = 0; desc_count = 0;
    frame_valid = 0; frame_dst = 0; promisc_en = 0; all_mcast_en = 0; bcast_en = 0;
    reset_mode = 0; rb_ptr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!load_busy && !load_done_irq && !mem_req_valid, "reset R5",
          {load_busy, load_done_irq, mem_req_valid}, 0);
    check(!frame_accept && !frame_reject, "reset R11", {frame_accept, frame_reject}, 0);
    rb_check(0, 48'h0, "R12 reset entry");

    // narrow load, three entries, entries 0 and 2 enabled
    put_entry(32'h100, 2, 0, A0); put_entry(32'h100, 2, 1, A1);
    put_entry(32'h100, 2, 2, A2); put_mask(32'h100, 2, 3, 16'h0005);
    run_load(32'h100, 1'b0, 16'h0003, 1'b0);
    rb_check(0, A0, "R3 entry0");
    rb_check(1, A1, "R3 entry1");
    rb_check(2, A2, "R3 entry2");
    @(negedge clk); reset_mode = 1'b0; #1;
    check({rb_word_hi, rb_word_mid, rb_word_lo} == 48'h0, "R12 gated",
          {rb_word_hi, rb_word_mid, rb_word_lo}, 0);

    send(A0, 1, 2'd0);                  // R10
    send(A1, 0, 2'd0);                  // R10 disabled entry
    send(A2, 1, 2'd0);                  // R10
    send(48'h0000_0000_0042, 0, 2'd0);  // R10 no match
    promisc_en = 1'b1;
    send(48'h1234_5678_9A00, 1, 2'd1);  // R7
    send(48'h0000_0000_0001, 0, 2'd0);  // R7 multicast not covered
    promisc_en = 1'b0; all_mcast_en = 1'b1;
    send(48'h5E00_0000_0001, 1, 2'd2);  // R8
    send(BC, 1, 2'd2);                  // R8 includes broadcast
    all_mcast_en = 1'b0; bcast_en = 1'b1;
    send(BC, 1, 2'd3);                  // R9
    send(48'h0000_0000_0033, 0, 2'd0);  // R9 other multicast
    bcast_en = 1'b0;
    send(BC, 0, 2'd0);                  // R9 off
    repeat (3) @(negedge clk);

    // wide load, count upper bits set, second start ignored (R1, R3, R4)
    mem[(32'h200 + 4*1) >> 1] = 16'h0; // clean
    put_entry(32'h200, 4, 0, B0); put_entry(32'h200, 4, 1, B1);
    put_mask(32'h200, 4, 2, 16'h0002);
    run_load(32'h200, 1'b1, 16'h0022, 1'b1);
    rb_check(0, B0, "R3 wide entry0");
    rb_check(1, B1, "R3 wide entry1");
    rb_check(2, A2, "R1 entry2 kept");
    @(negedge clk); reset_mode = 1'b0;
    send(B0, 0, 2'd0);                  // R4 bit0 cleared
    send(B1, 1, 2'd0);                  // R4 bit1 set
    send(A2, 0, 2'd0);                  // R4 bit2 cleared

    // zero count: mask fetch only (R1)
    put_mask(32'h300, 2, 0, 16'hFFFF);
    run_load(32'h300, 1'b0, 16'h0040, 1'b0);
    send(A2, 1, 2'd0);
    send(B0, 1, 2'd0);
    repeat (4) @(negedge clk);
    check(exp_verdict_q.size() == 0, "R11 verdict count", 64'(exp_verdict_q.size()), 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule